// File: doc/BRIEF.md
# Programmable Binary Rate Multiplier

This block divides a stream of clock-enable ticks by 64 and passes on a chosen fraction of them. A six-bit binary counter steps through 64 states. A six-bit rate word M picks a binary-weighted subset of those states, and each picked state produces one output pulse. Over any 64 counting clocks the pulse output therefore fires exactly M times. The pulses are spread as evenly as binary weighting allows. All pulses are one clock wide and synchronous to the clock; the block never gates a clock.

Counting takes place only when the clear, hold and stall controls are all low. The hold control also blocks the pulse decode. The primary pulse output `z_n` is active low. A second output `y` merges those pulses with a combining input `unity_in`, so `y` carries the inverse of `unity_in` whenever the decode is blocked. A terminal output `en_out_n` goes low in the last state of a counting cycle. Two stages chain into a 12-bit multiplier as follows:
- The upper stage's `en_out_n` drives both `en_n` and `strobe` of the lower stage.
- Each stage's `z_n` drives the other stage's `unity_in`.
- The combined pulses are read from `y`.

Top module: `rate_mult6`

## Requirements
- R1: While `clr`, `strobe` and `en_n` are all low, the internal count advances by one (modulo 64) on each rising clock edge. Otherwise the count holds, except as set by R2.
- R2: `clr` is a synchronous active-high clear. It sets the count to 0. While `clr` is high, `z_n` and `en_out_n` are high.
- R3: With the counter running, `z_n` is low in a state c ≠ 63 exactly when bit `rate[5-t]` is 1, where t is the number of trailing one bits of c. Bit 5 of `rate` thus selects the 32 states with c[0]=0, and bit 0 selects only state 31. State 63 never produces a pulse, and no state is selected by two bits.
- R4: Over 64 consecutive counting clocks that start from count 0, `z_n` is low on exactly M clocks, where M is the value of `rate`. When M is 0, `z_n` stays high.
- R5: While `strobe` is high, `z_n` stays high and the count holds.
- R6: `y` equals NOT(`z_n` AND `unity_in`). With the decode blocked, `y` is therefore the inverse of `unity_in`.
- R7: `en_out_n` is low exactly while the counter is running and the count is 63.
- R8: When two stages are chained as described, the lower stage's `y` pulses exactly 64·A + B times per 4096 clocks, where A is the rate of the upper stage and B is the rate of the lower stage. Both stages' `y` outputs are equal.
- R9: While `en_n` is high, `z_n` stays high and `en_out_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high |
| strobe | input | 1 | High blocks counting and the pulse decode |
| en_n | input | 1 | Counting enable, active low |
| rate | input | 6 | Rate word M, pulses per 64 counting clocks |
| unity_in | input | 1 | Combining input for `y` |
| z_n | output | 1 | Rate pulse, active low, one clock wide |
| y | output | 1 | NOT(`z_n` AND `unity_in`) |
| en_out_n | output | 1 | Low in the terminal state while running |
| | | | |

## Verification
The count is not visible at the ports. The hardest case is proving that a stalled or blocked counter keeps its exact state, and does not merely stop pulsing. The bench stops counting in the middle of a cycle at a state that would otherwise pulse. It then checks that the same state pulses on the first clock after release. It also checks that the terminal output arrives after exactly the number of clocks the held count predicts. The 12-bit chain is the other hard case, because it needs the upper stage's terminal state never to coincide with its own pulses. Full 4096-clock windows at boundary rates (0, 1, 64, 65, 4095 and an alternating pattern) confirm that no pulse is lost when the two stages overlap.

// File: rtl/rate_mult6.sv
module rate_mult6 #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         strobe,
  input  logic         en_n,
  input  logic [W-1:0] rate,
  input  logic         unity_in,
  output logic         z_n,
  output logic         y,
  output logic         en_out_n
);
  localparam logic [W-1:0] LAST = '1;

  logic [W-1:0] cnt;
  logic [W-1:0] hit;
  logic         run;

  assign run = ~clr & ~strobe & ~en_n;

  always_ff @(posedge clk)
    if (clr)      cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;

  // bit k picks states whose low bits are 0 followed by (W-1-k) ones
  for (genvar k = 0; k < W; k++) begin : g_dec
    localparam int J = W - 1 - k;
    if (J == 0) begin : g_lsb
      assign hit[k] = rate[k] & ~cnt[0];
    end else begin : g_up
      assign hit[k] = rate[k] & ~cnt[J] & (&cnt[J-1:0]);
    end
  end

  assign z_n      = ~(run & (|hit));
  assign y        = ~(z_n & unity_in);
  assign en_out_n = ~(run & (cnt == LAST));

  a_r1_advance: assert property (@(posedge clk) disable iff (clr)
    run |=> cnt == $past(cnt) + 1'b1);
  a_r1_hold: assert property (@(posedge clk) disable iff (clr)
    !run |=> $stable(cnt));
  a_r2_clear: assert property (@(posedge clk)
    clr |=> cnt == '0);
  a_r3_disjoint: assert property (@(posedge clk) disable iff (clr)
    $onehot0(hit));
  a_r4_zero_rate: assert property (@(posedge clk) disable iff (clr)
    rate == '0 |-> z_n);
  a_r5_strobe_quiet: assert property (@(posedge clk) disable iff (clr)
    strobe |-> z_n && en_out_n);
  a_r7_wrap: assert property (@(posedge clk) disable iff (clr)
    !en_out_n |=> cnt == '0);
  a_r9_enable_quiet: assert property (@(posedge clk) disable iff (clr)
    en_n |-> z_n && en_out_n);
endmodule

// File: tb/test_rate_mult6.sv
module test_rate_mult6;
  logic       clk = 0;
  logic       clr = 1, strobe = 0, en_n = 0, unity_tb = 1, casc = 0;
  logic [5:0] rate = 0, rate_lo = 0;
  logic       z_a, y_a, eo_a, z_b, y_b, eo_b, unity_a;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  assign unity_a = casc ? z_b : unity_tb;

  rate_mult6 i_rate_mult6 (.clk(clk), .clr(clr), .strobe(strobe), .en_n(en_n),
    .rate(rate), .unity_in(unity_a), .z_n(z_a), .y(y_a), .en_out_n(eo_a));
  rate_mult6 i_rate_mult6_lo (.clk(clk), .clr(clr), .strobe(eo_a), .en_n(eo_a),
    .rate(rate_lo), .unity_in(z_a), .z_n(z_b), .y(y_b), .en_out_n(eo_b));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_pulse(input int c, input logic [5:0] m);
    int t = 0;
    if (c == 63) return 0;
    while (c[t] == 1'b1) t++;
    return m[5 - t];
  endfunction

  // drive at negedge, then sample 1 ns later
  task automatic cyc(input logic c, input logic s, input logic e);
    @(negedge clk);
    clr = c; strobe = s; en_n = e;
    #1;
  endtask

  task automatic t_reset();
    unity_tb = 1; rate = 6'h3f;
    cyc(1, 0, 0);
    chk("R2 z_n in clear", z_a, 1);
    chk("R2 en_out_n in clear", eo_a, 1);
    chk("R6 y in clear", y_a, 0);
  endtask

  task automatic t_sweep();
    unity_tb = 1;
    for (int m = 0; m < 64; m++) begin
      int lows = 0, bad = 0, eo_bad = 0;
      rate = 6'(m);
      cyc(1, 0, 0);
      for (int i = 0; i < 64; i++) begin
        cyc(0, 0, 0);
        if (z_a == 0) lows++;
        if (z_a !== !model_pulse(i, rate)) bad++;
        if (eo_a !== (i == 63 ? 1'b0 : 1'b1)) eo_bad++;
        if (y_a !== !z_a) bad++;
      end
      chk("R4 pulses per 64", lows, m);
      chk("R3 pulse placement", bad, 0);
      chk("R7 terminal position", eo_bad, 0);
    end
  endtask

  task automatic t_hold();
    int quiet = 0, idx = -1;
    rate = 6'h3f; unity_tb = 1;
    cyc(1, 0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 1);
      if (z_a !== 1 || eo_a !== 1) quiet++;
    end
    chk("R9 stall keeps outputs high", quiet, 0);
    quiet = 0;
    for (int i = 0; i < 5; i++) begin
      cyc(0, 1, 0);
      if (z_a !== 1 || eo_a !== 1 || y_a !== 0) quiet++;
    end
    chk("R5 strobe blocks pulses", quiet, 0);
    cyc(0, 0, 0);
    chk("R1 held state 10 pulses on release", z_a, 0);
    for (int i = 1; i < 64 && idx < 0; i++) begin
      cyc(0, 0, 0);
      if (eo_a == 0) idx = i;
    end
    chk("R1 terminal after held count", idx, 53);
  endtask

  task automatic t_clear_mid();
    int idx = -1;
    rate = 6'h3f;
    cyc(1, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0);
    cyc(1, 0, 0);
    chk("R2 clear forces z_n high mid-cycle", z_a, 1);
    for (int i = 0; i < 64 && idx < 0; i++) begin
      cyc(0, 0, 0);
      if (eo_a == 0) idx = i;
    end
    chk("R2 count restarts at 0", idx, 63);
  endtask

  task automatic t_unity();
    int bad = 0;
    rate = 6'h3f;
    cyc(1, 0, 0);
    unity_tb = 0; cyc(0, 1, 0);
    chk("R6 y with blocked decode, unity 0", y_a, 1);
    unity_tb = 1; cyc(0, 1, 0);
    chk("R6 y with blocked decode, unity 1", y_a, 0);
    unity_tb = 0;
    for (int i = 0; i < 16; i++) begin
      cyc(0, 0, 0);
      if (y_a !== 1) bad++;
    end
    chk("R6 unity 0 masks pulses", bad, 0);
    unity_tb = 1;
  endtask

  task automatic t_cascade(input int n);
    int hits = 0, diff = 0;
    casc = 1; rate = 6'(n >> 6); rate_lo = 6'(n & 63);
    cyc(1, 0, 0);
    for (int i = 0; i < 4096; i++) begin
      cyc(0, 0, 0);
      if (y_b == 1) hits++;
      if (y_a !== y_b) diff++;
    end
    chk("R8 chained pulses per 4096", hits, n);
    chk("R8 both y equal", diff, 0);
    casc = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_clear_mid();
    t_unity();
    t_cascade(0);
    t_cascade(1);
    t_cascade(64);
    t_cascade(65);
    t_cascade(2730);
    t_cascade(4095);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule